// File: doc/BRIEF.md
# Content-Aware Packet Port Director

This block picks the egress ports for each packet received on a two-port adapter. The adapter has two external ports, A and B. It also has four host-facing ports: C and D serve traffic that arrives on A, and E and F serve traffic that arrives on B. A rule engine upstream has already classified the packet. The block receives that result with a packet-level valid/ready handshake: the ingress port, a match flag, the matched rule's action, and a destination port index. One cycle later it returns a destination bitmap, or a drop indication.

A static operating mode sets the default forwarding:

- **Bypass:** the packet goes to the host when it matches, and to the other wire otherwise.
- **Tap:** the packet always goes to the other wire, and a matching packet is also copied to the host.
- **Filtering NIC:** the packet goes to the host when it matches, and is discarded otherwise.

A matched rule can then change that default. It can discard the packet, redirect it to a single port, or mirror it to one extra port.

Top module: `pd_port_director`

## Requirements
- R1: Port bitmap bit positions are A=0, B=1, C=2, D=3, E=4, F=5, and port indices on `in_dest` use the same numbering. `in_ingress` is 0 for A and 1 for B. `cfg_mode` is 0 for bypass, 1 for tap and 2 for filtering NIC. `in_action` is 0 for none, 1 for drop, 2 for redirect and 3 for mirror. In bypass mode with action none, a matching packet from A goes to C and D, and a non-matching one goes to B. Symmetrically, a matching packet from B goes to E and F, and a non-matching one goes to A.
- R2: In tap mode with action none, every packet goes to the opposite external port. A matching packet also goes to its ingress side's two host ports.
- R3: In filtering NIC mode with action none, a matching packet goes to its ingress side's two host ports, and a non-matching packet is dropped.
- R4: Mode value 3 behaves exactly like filtering NIC mode.
- R5: A matching packet with action drop yields an all-zero bitmap with `out_drop` high, in every mode.
- R6: A matching packet with action redirect goes only to the port named by `in_dest`.
- R7: A matching packet with action mirror goes to the mode's default set plus the port named by `in_dest`.
- R8: When `in_match` is low, `in_action` and `in_dest` have no effect on the result.
- R9: The result never contains the ingress port. `out_drop` is high exactly when the bitmap is all zero. For example, a redirect to the ingress port is a drop.
- R10: A `in_dest` value of 6 or 7 names no port. It adds nothing under mirror, and it makes a redirect a drop.
- R11: A decision accepted on a cycle where `in_valid` and `in_ready` are both high appears on the outputs, with `out_valid` high, after the next clock edge.
- R12: While `out_valid` is high and `out_ready` is low, the outputs hold steady and `in_ready` is low.
- R13: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Operating mode, held by a configuration register |
| in_valid | input | 1 | A packet decision request is present |
| in_ready | output | 1 | The block can accept a request |
| in_ingress | input | 1 | Ingress external port (0=A, 1=B) |
| in_match | input | 1 | A rule matched the packet |
| in_action | input | 2 | Action of the matched rule |
| in_dest | input | 3 | Destination port index of the matched rule |
| out_valid | output | 1 | A decision is presented |
| out_ready | input | 1 | The consumer takes the decision |
| out_map | output | 6 | Egress port bitmap |
| out_drop | output | 1 | The packet is discarded |

## Verification
The checker assumes that `cfg_mode` only changes while no decision is in flight. It also assumes that a request held under backpressure does not change its fields. The stimulus keeps to both: it sets the mode together with each request and consumes each result before moving on. The checker records the ingress port at each accepted request, so the no-reflection property depends on requests being accepted in order, one at a time. The stall test changes the waiting request's fields on purpose. This shows that the block ignores a request until `in_ready` rises.

// File: rtl/pd_pkg.sv
// Shared constants and encodings for the packet port director.
// Assumes exactly two external ports that serve as each other's opposite.
package pd_pkg;
    localparam int NUM_EXT      = 2;
    localparam int HOST_PER_EXT = 2;
    localparam int NUM_PORTS    = NUM_EXT * (1 + HOST_PER_EXT);
    localparam int PORT_IDX_W   = $clog2(NUM_PORTS);
    localparam int EXT_IDX_W    = (NUM_EXT > 1) ? $clog2(NUM_EXT) : 1;

    typedef logic [NUM_PORTS-1:0] port_map_t;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_TAP    = 2'd1,
        MODE_FILTER = 2'd2,
        MODE_RSVD   = 2'd3
    } fwd_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_DROP     = 2'd1,
        ACT_REDIRECT = 2'd2,
        ACT_MIRROR   = 2'd3
    } rule_act_e;
endpackage

// File: rtl/pd_mode_base.sv
// Computes the mode's default forwarding set from the ingress port and the match flag.
// Assumes the external ports occupy bits 0..NUM_EXT-1 and the host ports follow, grouped by ingress.
module pd_mode_base
    import pd_pkg::*;
(
    input  logic [1:0]           mode,
    input  logic [EXT_IDX_W-1:0] ingress,
    input  logic                 match,
    output port_map_t            base_map
);
    port_map_t host_set;
    port_map_t wire_set;

    // Host ports of the ingress side, and the opposite external port.
    always_comb begin
        host_set = '0;
        wire_set = '0;
        for (int k = 0; k < HOST_PER_EXT; k++) begin
            host_set[NUM_EXT + int'(ingress) * HOST_PER_EXT + k] = 1'b1;
        end
        wire_set[(int'(ingress) + 1) % NUM_EXT] = 1'b1;
    end

    // Apply the mode's default policy; the reserved encoding falls to filtering.
    always_comb begin
        unique case (fwd_mode_e'(mode))
            MODE_BYPASS: base_map = match ? host_set : wire_set;
            MODE_TAP:    base_map = wire_set | (match ? host_set : '0);
            default:     base_map = match ? host_set : '0;
        endcase
    end
endmodule

// File: rtl/pd_dest_decode.sv
// One-hot decodes a rule's destination port index; an out-of-range index yields no bit.
// Assumes the index width covers NUM_PORTS.
module pd_dest_decode
    import pd_pkg::*;
(
    input  logic [PORT_IDX_W-1:0] dest_idx,
    output port_map_t             dest_map
);
    // One comparator per port.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
        assign dest_map[p] = (dest_idx == PORT_IDX_W'(p));
    end
endmodule

// File: rtl/pd_action_merge.sv
// Combines the default set with the matched rule's action, and removes the ingress port.
// Assumes the action is meaningful only while match is high.
module pd_action_merge
    import pd_pkg::*;
(
    input  logic                 match,
    input  logic [1:0]           action,
    input  logic [EXT_IDX_W-1:0] ingress,
    input  port_map_t            base_map,
    input  port_map_t            dest_map,
    output port_map_t            fwd_map,
    output logic                 fwd_drop
);
    port_map_t pre_map;
    port_map_t ingress_bit;

    // Select the set that the rule action gives.
    always_comb begin
        pre_map = base_map;
        if (match) begin
            unique case (rule_act_e'(action))
                ACT_DROP:     pre_map = '0;
                ACT_REDIRECT: pre_map = dest_map;
                ACT_MIRROR:   pre_map = base_map | dest_map;
                default:      pre_map = base_map;
            endcase
        end
    end

    // Never send a packet back out of its ingress port; an empty set means a drop.
    always_comb begin
        ingress_bit = '0;
        ingress_bit[ingress] = 1'b1;
        fwd_map  = pre_map & ~ingress_bit;
        fwd_drop = (fwd_map == '0);
    end
endmodule

// File: rtl/pd_port_director.sv
// Packet port director top: one registered forwarding decision per accepted request.
// Assumes cfg_mode is static while decisions are in flight; a one-entry output register
// carries the result with a valid/ready handshake on both sides.
module pd_port_director
    import pd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            cfg_mode,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [EXT_IDX_W-1:0]  in_ingress,
    input  logic                  in_match,
    input  logic [1:0]            in_action,
    input  logic [PORT_IDX_W-1:0] in_dest,
    output logic                  out_valid,
    input  logic                  out_ready,
    output logic [NUM_PORTS-1:0]  out_map,
    output logic                  out_drop
);
    port_map_t base_map;
    port_map_t dest_map;
    port_map_t fwd_map;
    logic      fwd_drop;
    logic      in_fire;

    pd_mode_base u_base (
        .mode     (cfg_mode),
        .ingress  (in_ingress),
        .match    (in_match),
        .base_map (base_map)
    );

    pd_dest_decode u_dec (
        .dest_idx (in_dest),
        .dest_map (dest_map)
    );

    pd_action_merge u_merge (
        .match    (in_match),
        .action   (in_action),
        .ingress  (in_ingress),
        .base_map (base_map),
        .dest_map (dest_map),
        .fwd_map  (fwd_map),
        .fwd_drop (fwd_drop)
    );

    // Accept when the output slot is empty or is being emptied this cycle.
    assign in_ready = !out_valid || out_ready;
    assign in_fire  = in_valid && in_ready;

    // Output slot: load on accept, clear when consumed without a refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_map   <= '0;
            out_drop  <= 1'b0;
        end else if (in_fire) begin
            out_valid <= 1'b1;
            out_map   <= fwd_map;
            out_drop  <= fwd_drop;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/pd_port_director_chk.sv
// Property checker for the port director; attached to every instance by bind.
// Assumes requests are accepted in order, one per cycle at most.
module pd_port_director_chk
    import pd_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  in_ready,
    input logic [EXT_IDX_W-1:0]  in_ingress,
    input logic                  out_valid,
    input logic                  out_ready,
    input logic [NUM_PORTS-1:0]  out_map,
    input logic                  out_drop
);
    logic [EXT_IDX_W-1:0] held_ing;

    // Remember the ingress port of the request most recently accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)                    held_ing <= '0;
        else if (in_valid && in_ready) held_ing <= in_ingress;
    end

    // R9
    drop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_drop) |-> (out_map == '0));

    // R9
    no_reflect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_map[held_ing]);

    // R11
    accept_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R12
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_map) && $stable(out_drop)));

    // R12
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
endmodule

bind pd_port_director pd_port_director_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_ingress (in_ingress),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_map    (out_map),
    .out_drop   (out_drop)
);

// File: tb/pd_port_director_tb_top.sv
module pd_port_director_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_mode;
    logic       in_valid;
    logic       in_ready;
    logic       in_ingress;
    logic       in_match;
    logic [1:0] in_action;
    logic [2:0] in_dest;
    logic       out_valid;
    logic       out_ready;
    logic [5:0] out_map;
    logic       out_drop;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pd_port_director dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .in_valid(in_valid), .in_ready(in_ready), .in_ingress(in_ingress),
        .in_match(in_match), .in_action(in_action), .in_dest(in_dest),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_map(out_map), .out_drop(out_drop)
    );

    // {mode, ingress, match, action, dest, expected map FEDCBA, expected drop}
    localparam int NV = 26;
    localparam logic [15:0] VEC [NV] = '{
        {2'd0,1'b0,1'b1,2'd0,3'd0,6'b001100,1'b0},  // R1
        {2'd0,1'b0,1'b0,2'd0,3'd0,6'b000010,1'b0},  // R1
        {2'd0,1'b1,1'b1,2'd0,3'd0,6'b110000,1'b0},  // R1
        {2'd0,1'b1,1'b0,2'd0,3'd0,6'b000001,1'b0},  // R1
        {2'd1,1'b0,1'b1,2'd0,3'd0,6'b001110,1'b0},  // R2
        {2'd1,1'b0,1'b0,2'd0,3'd0,6'b000010,1'b0},  // R2
        {2'd1,1'b1,1'b1,2'd0,3'd0,6'b110001,1'b0},  // R2
        {2'd1,1'b1,1'b0,2'd0,3'd0,6'b000001,1'b0},  // R2
        {2'd2,1'b0,1'b1,2'd0,3'd0,6'b001100,1'b0},  // R3
        {2'd2,1'b0,1'b0,2'd0,3'd0,6'b000000,1'b1},  // R3
        {2'd2,1'b1,1'b1,2'd0,3'd0,6'b110000,1'b0},  // R3
        {2'd2,1'b1,1'b0,2'd0,3'd0,6'b000000,1'b1},  // R3
        {2'd3,1'b0,1'b1,2'd0,3'd0,6'b001100,1'b0},  // R4
        {2'd3,1'b1,1'b0,2'd0,3'd0,6'b000000,1'b1},  // R4
        {2'd1,1'b0,1'b1,2'd1,3'd2,6'b000000,1'b1},  // R5
        {2'd0,1'b1,1'b1,2'd1,3'd0,6'b000000,1'b1},  // R5
        {2'd0,1'b0,1'b1,2'd2,3'd4,6'b010000,1'b0},  // R6
        {2'd1,1'b0,1'b1,2'd2,3'd0,6'b000000,1'b1},  // R9 redirect to ingress
        {2'd1,1'b1,1'b1,2'd3,3'd2,6'b110101,1'b0},  // R7
        {2'd2,1'b0,1'b1,2'd3,3'd1,6'b001110,1'b0},  // R7
        {2'd0,1'b1,1'b1,2'd3,3'd1,6'b110000,1'b0},  // R9 mirror to ingress
        {2'd0,1'b0,1'b0,2'd1,3'd0,6'b000010,1'b0},  // R8
        {2'd2,1'b1,1'b0,2'd2,3'd2,6'b000000,1'b1},  // R8
        {2'd0,1'b0,1'b0,2'd3,3'd4,6'b000010,1'b0},  // R8
        {2'd0,1'b0,1'b1,2'd2,3'd6,6'b000000,1'b1},  // R10
        {2'd1,1'b0,1'b1,2'd3,3'd7,6'b001110,1'b0}   // R10
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic ing, input logic mt,
                         input logic [1:0] a, input logic [2:0] d);
        cfg_mode = m; in_ingress = ing; in_match = mt; in_action = a; in_dest = d;
    endtask

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        drive(2'd0, 1'b0, 1'b0, 2'd0, 3'd0);
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13", {6'b0, out_valid, in_ready}, {6'b0, 1'b0, 1'b1});
        rst_n = 1'b1;

        // Table walk: one request per cycle, result sampled one cycle later (R11)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][15:14], VEC[i][13], VEC[i][12], VEC[i][11:10], VEC[i][9:7]);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R11 vec%0d valid", i), {7'b0, out_valid}, 8'd1);
            check($sformatf("R1-table vec%0d", i), {1'b0, out_map, out_drop},
                  {1'b0, VEC[i][6:1], VEC[i][0]});
        end
        @(negedge clk);
        check("R11 idle", {7'b0, out_valid}, 8'd0);

        // R12 stall: first result held, second request blocked
        drive(2'd0, 1'b0, 1'b1, 2'd0, 3'd0);
        out_ready = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check("R12 first", {out_valid, in_ready, out_map}, {1'b1, 1'b0, 6'b001100});
        drive(2'd0, 1'b0, 1'b0, 2'd0, 3'd0);
        @(negedge clk);
        check("R12 held", {out_valid, in_ready, out_map}, {1'b1, 1'b0, 6'b001100});
        @(negedge clk);
        check("R12 held2", {1'b0, out_map, out_drop}, {1'b0, 6'b001100, 1'b0});
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R12 release", {out_valid, 1'b0, out_map}, {1'b1, 1'b0, 6'b000010});
        @(negedge clk);
        check("R12 drain", {7'b0, out_valid}, 8'd0);

        // R13 reset clears a pending result
        drive(2'd1, 1'b1, 1'b1, 2'd0, 3'd0);
        out_ready = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R13 reset flush", {6'b0, out_valid, in_ready}, {6'b0, 1'b0, 1'b1});
        rst_n = 1'b1; out_ready = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule